// File: doc/BRIEF.md
# Reference Tick Generator

This block turns a free-running input clock into a slow periodic enable tick. The input clock is the block's own clock, and each of its cycles counts as one input period. Three stages in series set the overall rate. The first is a source stage that either blocks the clock, thins it by a fixed 32, or lets every cycle through. The second is a power-of-two prescaler. The third is a divide-by-(k+1) counter.

Each stage takes its setting from its own field. These are a 2-bit source mode, a 3-bit prescaler exponent and an 8-bit divider value. The output is a one-cycle pulse that downstream logic uses as a clock enable. The expected input range is about 32 kHz to 20 MHz, with 32.768 kHz the usual choice. Whenever any of the three fields changes, every stage counter restarts. Because of that restart, no partial period is ever produced.

Top module: `refdiv_tick_gen`

## Requirements
- R1: While reset is held, and until the synchronised release has taken effect, `tick_o` stays low.
- R2: With `src_sel` = 2'b00 (off), no tick is produced.
- R3: With `src_sel` = 2'b01 (reserved), the block behaves as off and produces no tick.
- R4: With `src_sel` = 2'b10, the source stage passes one cycle in 32. The tick period is 32 · 2^`pre_code` · (`div_code`+1) cycles.
- R5: With `src_sel` = 2'b11, every cycle passes the source stage. The tick period is 2^`pre_code` · (`div_code`+1) cycles.
- R6: A prescaler code n contributes a factor of 2^n, ranging from 1 at code 0 to 128 at code 7.
- R7: A divider code k contributes a factor of k+1, ranging from 1 at code 0 to 256 at code 255.
- R8: When the total ratio is 1 (`src_sel` = 2'b11, `pre_code` = 0, `div_code` = 0), `tick_o` is high in every cycle.
- R9: When the total ratio is above 1, each tick lasts exactly one cycle.
- R10: A change to any of the three fields clears all stage counters, and no tick is produced in the cycle after the change. The first tick under the new setting appears R+1 cycles after the new setting is first applied, where R is the total ratio. Later ticks follow every R cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; each cycle is one source period |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| src_sel | input | 2 | Source mode: 00 off, 01 reserved (off), 10 divide by 32, 11 direct |
| pre_code | input | 3 | Prescaler exponent n; the stage divides by 2^n |
| div_code | input | 8 | Divider value k; the stage divides by k+1 |
| tick_o | output | 1 | One-cycle reference tick |

## Verification
The output has exactly one register after the last counter, so the cycle of the first tick is fixed. A setting applied between clock edges clears the counters at the next edge, and the first tick is then visible in the sampling slot R+1 cycles later. Each scenario changes its setting on a falling edge and counts falling edges until the tick appears. It compares that count against R+1, computed from the field values, and then checks the gap to the next tick against R. Width checks look at the single sample after a tick.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF  = 2'b00,
    SRC_RSV  = 2'b01,
    SRC_DIV  = 2'b10,
    SRC_PASS = 2'b11
  } src_mode_e;
endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_n = sync_q[STAGES-1];
endmodule

// File: rtl/refdiv_stage.sv
module refdiv_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         run_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap = en & (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refdiv_tick_gen.sv
module refdiv_tick_gen
  import refdiv_pkg::*;
#(
  parameter int FIX_LOG2 = 5,
  parameter int PRE_W    = 3,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick_o
);
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;
  localparam int CFG_W     = SEL_W + PRE_W + DIV_W;

  logic               run_n;
  logic [CFG_W-1:0]   cfg_now, cfg_q;
  logic               chg, clr;
  logic               src_en, pre_wrap, div_wrap;
  logic [PRE_CNT_W-1:0] pre_lim;
  logic               tick_d, tick_q;

  refdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  assign cfg_now = {src_sel, pre_code, div_code};
  assign chg     = (cfg_now != cfg_q);
  assign clr     = chg;

  generate
    if (FIX_LOG2 > 0) begin : g_fix
      logic fix_wrap;
      refdiv_stage #(.W(FIX_LOG2)) u_fix (
        .clk   (clk),
        .run_n (run_n),
        .clr   (clr),
        .en    (src_sel == SRC_DIV),
        .lim   ({FIX_LOG2{1'b1}}),
        .wrap  (fix_wrap)
      );
      assign src_en = (src_sel == SRC_PASS) | fix_wrap;
    end else begin : g_nofix
      assign src_en = src_sel[1];
    end
  endgenerate

  always_comb begin
    pre_lim = '0;
    for (int i = 0; i < PRE_CNT_W; i++) begin
      pre_lim[i] = (PRE_W'(i) < pre_code);
    end
  end

  refdiv_stage #(.W(PRE_CNT_W)) u_pre (
    .clk   (clk),
    .run_n (run_n),
    .clr   (clr),
    .en    (src_en),
    .lim   (pre_lim),
    .wrap  (pre_wrap)
  );

  refdiv_stage #(.W(DIV_W)) u_div (
    .clk   (clk),
    .run_n (run_n),
    .clr   (clr),
    .en    (pre_wrap),
    .lim   (div_code),
    .wrap  (div_wrap)
  );

  assign tick_d = div_wrap & ~chg;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      cfg_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/refdiv_tick_gen_chk.sv
module refdiv_tick_gen_chk #(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             run_n,
  input logic [1:0]       src_sel,
  input logic [PRE_W-1:0] pre_code,
  input logic [DIV_W-1:0] div_code,
  input logic             tick_o
);
  logic unity;
  assign unity = (src_sel == 2'b11) && (pre_code == '0) && (div_code == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !run_n |-> !tick_o);

  // R2 R3
  off_silent_chk: assert property (@(posedge clk) disable iff (!run_n)
    !src_sel[1] |=> !tick_o);

  // R8
  unity_every_cycle_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) && unity && $past(unity) |=> tick_o);

  // R9
  single_cycle_chk: assert property (@(posedge clk) disable iff (!run_n)
    tick_o && !unity |=> !tick_o);

  // R10
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) && ({src_sel, pre_code, div_code} != $past({src_sel, pre_code, div_code}))
    |=> !tick_o);
endmodule

bind refdiv_tick_gen refdiv_tick_gen_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .run_n    (run_n),
  .src_sel  (src_sel),
  .pre_code (pre_code),
  .div_code (div_code),
  .tick_o   (tick_o)
);

// File: tb/sim_refdiv_tick_gen.sv
module sim_refdiv_tick_gen;
  logic       clk;
  logic       rst_n;
  logic [1:0] src_sel;
  logic [2:0] pre_code;
  logic [7:0] div_code;
  logic       tick_o;

  int checks;
  int fails;
  bit done;

  refdiv_tick_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .pre_code (pre_code),
    .div_code (div_code),
    .tick_o   (tick_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; src_sel = 2'b00; pre_code = 3'd0; div_code = 8'd0;
    repeat (4) @(negedge clk);
    check("R1", int'(tick_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(tick_o), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_off(input logic [1:0] sel, input string req);
    int seen;
    seen = 0;
    src_sel = sel; pre_code = 3'd0; div_code = 8'd0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick_o) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_ratio(input logic [1:0] sel, input logic [2:0] pre,
                         input logic [7:0] div, input bit gap, input string req);
    int r, n, gap_n;
    r = ((sel == 2'b10) ? 32 : 1) * (1 << pre) * (int'(div) + 1);
    if (gap) begin
      src_sel = 2'b00;
      repeat (3) @(negedge clk);
    end
    src_sel = sel; pre_code = pre; div_code = div;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < r + 6);
    check("R10", n, r + 1);
    gap_n = 0;
    do begin
      @(negedge clk);
      gap_n++;
      if (gap_n == 1 && r > 1) check("R9", int'(tick_o), 0);
    end while (!tick_o && gap_n < r + 6);
    check(req, gap_n, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    t_reset();
    t_off(2'b00, "R2");
    t_off(2'b01, "R3");
    t_ratio(2'b11, 3'd0, 8'd0, 1'b1, "R8");
    t_ratio(2'b11, 3'd0, 8'd4, 1'b1, "R5");
    t_ratio(2'b11, 3'd7, 8'd0, 1'b1, "R6");
    t_ratio(2'b11, 3'd2, 8'd0, 1'b1, "R6");
    t_ratio(2'b11, 3'd0, 8'd255, 1'b1, "R7");
    t_ratio(2'b10, 3'd0, 8'd0, 1'b1, "R4");
    t_ratio(2'b10, 3'd2, 8'd3, 1'b1, "R4");
    t_ratio(2'b10, 3'd7, 8'd1, 1'b1, "R4");
    t_ratio(2'b11, 3'd3, 8'd7, 1'b1, "R5");
    t_ratio(2'b11, 3'd1, 8'd2, 1'b0, "R10");
    t_ratio(2'b11, 3'd1, 8'd3, 1'b0, "R10");
    t_off(2'b01, "R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule